// File: doc/BRIEF.md
# Auto-Address-Increment Word Program Sequencer

This block runs the word-at-a-time sequential programming mode of a serial flash target. It watches chip-select and the serial input sampled on each rising serial clock, assembles whole bytes MSB first, and acts on a command only when chip-select goes high on a byte boundary. A session opens with the sequential-program opcode followed by a start address and two data bytes. Each later command in the same session carries only two data bytes and lands on the next word. For every accepted word the block issues two single-byte program requests on consecutive cycles: first the even byte, then the odd byte.

A counter models program time. While it runs, new word data is dropped. The serial output can be switched to act as a ready/busy line while chip-select is low. The session closes on a write-disable command, or when the word just written is the top word of the array. Closing the session also clears the write-enable latch.

Top module: `aai_word_seq`

## Requirements
- R1: Serial input bits are taken only on cycles where `sck_rise_i` is high and `cs_ni` is low. They are packed MSB first into bytes, and strobes seen while `cs_ni` is high have no effect.
- R2: A one-byte frame 06h sets the write-enable latch (`wel_o`). A one-byte frame 04h clears it and also ends an open session (`aai_active_o` low).
- R3: A session starts only on a frame of opcode ADh, three address bytes (most significant first) and two data bytes, received while `wel_o` is high, no session is open and `busy_o` is low. Any other ADh frame while no session is open is ignored.
- R4: On a start, bit 0 and all address bits at or above ADDR_W are ignored. On the cycle after chip-select rises, the block requests address A with bit 0 cleared and data byte 0. On the next cycle it requests A with bit 0 set and data byte 1.
- R5: While a session is open, a three-byte frame (ADh plus two data bytes) with `busy_o` low programs the word 2 above the previous word.
- R6: `busy_o` goes high on the cycle after a word is accepted and stays high for BUSY_CYCLES cycles. An ADh frame that completes while `busy_o` is high is ignored and does not advance the address.
- R7: A frame is discarded with no effect if chip-select rises mid-byte or after a byte count the command does not expect.
- R8: A one-byte frame 70h enables the ready/busy output and 80h disables it. When it is enabled and `cs_ni` is low, `so_oe_o` is high and `so_o` is 0 while busy and 1 when ready. Otherwise `so_oe_o` is low.
- R9: Accepting the word whose address bits [ADDR_W-1:1] are all ones ends the session and clears `wel_o`. While a session is open, `wel_o` stays high.
- R10: Program requests always come as an even-address request immediately followed by the odd address of the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip-select, active low |
| sck_rise_i | input | 1 | One-cycle strobe for a rising serial clock edge |
| mosi_i | input | 1 | Serial input bit, valid with `sck_rise_i` |
| prog_req_o | output | 1 | Single-byte program request |
| prog_addr_o | output | ADDR_W | Byte address of the request |
| prog_data_o | output | 8 | Byte value of the request |
| wel_o | output | 1 | Write-enable latch |
| aai_active_o | output | 1 | Sequential-program session open |
| busy_o | output | 1 | Program timer running |
| so_oe_o | output | 1 | Serial output driven as ready/busy |
| so_o | output | 1 | Ready/busy level, 1 = ready |

## Verification
Two things can land on the same clock edge: a follow-on word frame completing, and the program timer running out. Which one the block sees first decides whether the word is written or dropped. The bench sends follow-on frames after a sweep of idle gaps, so that chip-select rises a few cycles before, on, and after the last busy cycle. A behavioural reference model decides, clock by clock, whether each frame is accepted. Every output, including the request pair and the address advance, is compared against that model on every cycle.

// File: rtl/aai_seq_pkg.sv
package aai_seq_pkg;
   localparam logic [7:0] OP_SET_WEL   = 8'h06;
   localparam logic [7:0] OP_CLR_WEL   = 8'h04;
   localparam logic [7:0] OP_SEQ_PROG  = 8'hAD;
   localparam logic [7:0] OP_RB_ON     = 8'h70;
   localparam logic [7:0] OP_RB_OFF    = 8'h80;

   localparam int DATA_BYTES = 2;
   localparam int CTRL_LEN   = 1;

   typedef logic [7:0] byte_t;

   typedef enum logic {
      PH_IDLE = 1'b0,
      PH_ODD  = 1'b1
   } emit_ph_t;
endpackage

// File: rtl/aai_frame_rx.sv
module aai_frame_rx
   import aai_seq_pkg::*;
#(
   parameter int MAXB = 6
) (
   input  logic                              clk_i,
   input  logic                              rst_ni,
   input  logic                              cs_ni,
   input  logic                              sck_rise_i,
   input  logic                              mosi_i,
   output logic                              frame_done_o,
   output logic [$clog2(MAXB+2)-1:0]         frame_len_o,
   output logic [MAXB-1:0][7:0]              frame_bytes_o
);
   localparam int CNT_W = $clog2(MAXB + 2);
   localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(MAXB + 1);

   generate
      if (MAXB < 1) begin : g_bad_maxb
         $error("aai_frame_rx: MAXB must be at least 1");
      end
   endgenerate

   logic             cs_d;
   logic [2:0]       bit_cnt;
   logic [6:0]       shreg;
   logic [CNT_W-1:0] n_bytes;
   byte_t            byte_q [MAXB];
   logic             byte_end;

   assign byte_end = !cs_ni && sck_rise_i && (bit_cnt == 3'd7);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cs_d    <= 1'b1;
         bit_cnt <= '0;
         shreg   <= '0;
         n_bytes <= '0;
      end else begin
         cs_d <= cs_ni;
         if (cs_ni) begin
            bit_cnt <= '0;
            n_bytes <= '0;
         end else if (sck_rise_i) begin
            shreg   <= {shreg[5:0], mosi_i};
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7 && n_bytes != CNT_SAT) begin
               n_bytes <= n_bytes + 1'b1;
            end
         end
      end
   end

   for (genvar i = 0; i < MAXB; i++) begin : g_slot
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            byte_q[i] <= '0;
         end else if (byte_end && n_bytes == CNT_W'(i)) begin
            byte_q[i] <= {shreg, mosi_i};
         end
      end
      assign frame_bytes_o[i] = byte_q[i];
   end

   assign frame_done_o = cs_ni && !cs_d && (bit_cnt == 3'd0) && (n_bytes != '0);
   assign frame_len_o  = n_bytes;

   // R7: deselect always discards partial bits and the byte count
   p_clear_on_deselect_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cs_ni |=> (bit_cnt == 3'd0 && n_bytes == '0));

   // R1: strobes while deselected leave the shift register alone
   p_idle_shift_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cs_ni && sck_rise_i) |=> $stable(shreg));
endmodule

// File: rtl/aai_busy_timer.sv
module aai_busy_timer #(
   parameter int BUSY_CYCLES = 64
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic start_i,
   output logic busy_o
);
   localparam int CW = $clog2(BUSY_CYCLES + 1);
   localparam logic [CW-1:0] LOAD = CW'(BUSY_CYCLES);

   generate
      if (BUSY_CYCLES < 2) begin : g_bad_busy
         $error("aai_busy_timer: BUSY_CYCLES must cover the two request cycles");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt <= '0;
      end else if (start_i) begin
         cnt <= LOAD;
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign busy_o = (cnt != '0);

   // R6: an accepted word loads the full program time
   p_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_i |=> (busy_o && cnt == LOAD));

   // R6: the sequencer never restarts a running timer
   p_no_restart_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o |-> !start_i);
endmodule

// File: rtl/aai_prog_emit.sv
module aai_prog_emit
   import aai_seq_pkg::*;
#(
   parameter int ADDR_W = 18
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              fire_i,
   input  logic [ADDR_W-1:0] word_i,
   input  logic [7:0]        d0_i,
   input  logic [7:0]        d1_i,
   output logic              prog_req_o,
   output logic [ADDR_W-1:0] prog_addr_o,
   output logic [7:0]        prog_data_o
);
   localparam logic [ADDR_W-1:0] LSB = ADDR_W'(1);

   emit_ph_t ph;
   byte_t    d1_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ph          <= PH_IDLE;
         d1_q        <= '0;
         prog_req_o  <= 1'b0;
         prog_addr_o <= '0;
         prog_data_o <= '0;
      end else if (fire_i) begin
         ph          <= PH_ODD;
         d1_q        <= d1_i;
         prog_req_o  <= 1'b1;
         prog_addr_o <= word_i & ~LSB;
         prog_data_o <= d0_i;
      end else if (ph == PH_ODD) begin
         ph          <= PH_IDLE;
         prog_req_o  <= 1'b1;
         prog_addr_o <= prog_addr_o | LSB;
         prog_data_o <= d1_q;
      end else begin
         prog_req_o  <= 1'b0;
      end
   end

   // R10: an even request is followed at once by the odd byte of the same word
   p_pair_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (prog_req_o && !prog_addr_o[0]) |=>
         (prog_req_o && prog_addr_o[0] && $stable(prog_addr_o[ADDR_W-1:1])));

   // R4: an odd request only ever follows an even one
   p_odd_after_even_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (prog_req_o && prog_addr_o[0]) |-> ($past(prog_req_o) && !$past(prog_addr_o[0])));

   // R6: a new word never arrives while the odd byte is still pending
   p_fire_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fire_i |-> (ph == PH_IDLE));
endmodule

// File: rtl/aai_word_seq.sv
module aai_word_seq
   import aai_seq_pkg::*;
#(
   parameter int ADDR_W      = 18,
   parameter int ADDR_BYTES  = 3,
   parameter int BUSY_CYCLES = 64
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              cs_ni,
   input  logic              sck_rise_i,
   input  logic              mosi_i,
   output logic              prog_req_o,
   output logic [ADDR_W-1:0] prog_addr_o,
   output logic [7:0]        prog_data_o,
   output logic              wel_o,
   output logic              aai_active_o,
   output logic              busy_o,
   output logic              so_oe_o,
   output logic              so_o
);
   localparam int START_LEN = 1 + ADDR_BYTES + DATA_BYTES;
   localparam int NEXT_LEN  = 1 + DATA_BYTES;
   localparam int LEN_W     = $clog2(START_LEN + 2);
   localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(2);
   localparam logic [ADDR_W-1:0] LSB       = ADDR_W'(1);

   generate
      if (ADDR_W < 8 * (ADDR_BYTES - 1) + 1 || ADDR_W > 8 * ADDR_BYTES) begin : g_bad_addr
         $error("aai_word_seq: ADDR_W must fit the top address byte");
      end
   endgenerate

   logic                        done;
   logic [LEN_W-1:0]            len;
   logic [START_LEN-1:0][7:0]   fbytes;

   aai_frame_rx #(.MAXB(START_LEN)) u_rx (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .cs_ni        (cs_ni),
      .sck_rise_i   (sck_rise_i),
      .mosi_i       (mosi_i),
      .frame_done_o (done),
      .frame_len_o  (len),
      .frame_bytes_o(fbytes)
   );

   // start address: byte 1 is most significant, only ADDR_W bits kept
   logic [ADDR_W-1:0] start_addr;
   for (genvar b = 0; b < ADDR_W; b++) begin : g_abit
      assign start_addr[b] = fbytes[ADDR_BYTES - (b / 8)][b % 8];
   end

   logic              wel_q, active_q, rb_en_q;
   logic [ADDR_W-1:0] next_q;
   logic              busy;
   logic              is_ctrl, is_seq, start_ok, cont_ok, fire, last_word;
   logic [ADDR_W-1:0] word;
   byte_t             d0, d1;

   always_comb begin
      is_ctrl   = done && (len == LEN_W'(CTRL_LEN));
      is_seq    = done && (fbytes[0] == OP_SEQ_PROG) && !busy;
      start_ok  = is_seq && !active_q && wel_q && (len == LEN_W'(START_LEN));
      cont_ok   = is_seq && active_q && (len == LEN_W'(NEXT_LEN));
      fire      = start_ok || cont_ok;
      word      = start_ok ? (start_addr & ~LSB) : next_q;
      d0        = start_ok ? fbytes[START_LEN-2] : fbytes[1];
      d1        = start_ok ? fbytes[START_LEN-1] : fbytes[2];
      last_word = &word[ADDR_W-1:1];
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         wel_q    <= 1'b0;
         active_q <= 1'b0;
         rb_en_q  <= 1'b0;
         next_q   <= '0;
      end else begin
         if (is_ctrl) begin
            unique case (fbytes[0])
               OP_SET_WEL: wel_q <= 1'b1;
               OP_CLR_WEL: begin
                  wel_q    <= 1'b0;
                  active_q <= 1'b0;
               end
               OP_RB_ON:   rb_en_q <= 1'b1;
               OP_RB_OFF:  rb_en_q <= 1'b0;
               default: ;
            endcase
         end
         if (fire) begin
            if (last_word) begin
               active_q <= 1'b0;
               wel_q    <= 1'b0;
            end else begin
               active_q <= 1'b1;
               next_q   <= word + WORD_STEP;
            end
         end
      end
   end

   aai_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .start_i(fire),
      .busy_o (busy)
   );

   aai_prog_emit #(.ADDR_W(ADDR_W)) u_emit (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .fire_i     (fire),
      .word_i     (word),
      .d0_i       (d0),
      .d1_i       (d1),
      .prog_req_o (prog_req_o),
      .prog_addr_o(prog_addr_o),
      .prog_data_o(prog_data_o)
   );

   assign wel_o        = wel_q;
   assign aai_active_o = active_q;
   assign busy_o       = busy;
   assign so_oe_o      = rb_en_q && !cs_ni;
   assign so_o         = !busy;

   // R9: an open session always has the write-enable latch set
   p_active_needs_wel_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      active_q |-> wel_q);

   // R6: the running word address is frozen while programming
   p_addr_hold_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy |=> $stable(next_q));

   // R4: the running word address is always even
   p_word_even_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      active_q |-> !next_q[0]);
endmodule

// File: tb/tb_aai_word_seq.sv
module tb_aai_word_seq;
   localparam int CLK_PERIOD = 10;
   localparam int AW   = 18;
   localparam int BUSY = 100;
   localparam int TOP  = 1 << AW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1;
   logic sck = 1'b0;
   logic mosi = 1'b0;
   logic          prog_req, wel, act, busy, so_oe, so;
   logic [AW-1:0] prog_addr;
   logic [7:0]    prog_data;

   aai_word_seq #(.ADDR_W(AW), .ADDR_BYTES(3), .BUSY_CYCLES(BUSY)) dut (
      .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_rise_i(sck), .mosi_i(mosi),
      .prog_req_o(prog_req), .prog_addr_o(prog_addr), .prog_data_o(prog_data),
      .wel_o(wel), .aai_active_o(act), .busy_o(busy), .so_oe_o(so_oe), .so_o(so));

   always #(CLK_PERIOD/2) clk = ~clk;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   bit finished = 0;

   task automatic chk(string req, int actual, int expected);
      total++;
      if (actual != expected) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
      end
   endtask

   // reference model state
   bit m_wel, m_act, m_rb, m_prev_cs;
   int m_next, m_busy;
   bit q_bits[$];
   int qa[$], qd[$];
   bit e_req;
   int e_addr, e_data;
   int seen_a[$], seen_d[$], seen_c[$];

   always @(posedge clk) begin
      bit acc;
      int n, nb, w, d0, d1;
      int fb[8];
      if (!rst_n) begin
         m_wel = 0; m_act = 0; m_rb = 0; m_prev_cs = 1;
         m_next = 0; m_busy = 0; e_req = 0;
         q_bits.delete(); qa.delete(); qd.delete();
      end else begin
         acc = 0; w = 0; d0 = 0; d1 = 0;
         if (cs_n && !m_prev_cs) begin
            n = q_bits.size();
            if (n > 0 && n % 8 == 0) begin
               nb = n / 8;
               for (int i = 0; i < nb && i < 8; i++) begin
                  fb[i] = 0;
                  for (int j = 0; j < 8; j++) fb[i] = (fb[i] << 1) | int'(q_bits[8*i+j]);
               end
               if (nb == 1) begin
                  case (fb[0])
                     'h06: m_wel = 1;
                     'h04: begin m_wel = 0; m_act = 0; end
                     'h70: m_rb = 1;
                     'h80: m_rb = 0;
                     default: ;
                  endcase
               end else if (fb[0] == 'hAD && m_busy == 0) begin
                  if (!m_act && m_wel && nb == 6) begin
                     w = ((fb[1] << 16) | (fb[2] << 8) | fb[3]) % TOP;
                     w = w - (w % 2); d0 = fb[4]; d1 = fb[5]; acc = 1;
                  end else if (m_act && nb == 3) begin
                     w = m_next; d0 = fb[1]; d1 = fb[2]; acc = 1;
                  end
               end
               if (acc) begin
                  qa.push_back(w);     qd.push_back(d0);
                  qa.push_back(w + 1); qd.push_back(d1);
                  if (w + 2 >= TOP) begin m_act = 0; m_wel = 0; end
                  else begin m_act = 1; m_next = w + 2; end
               end
            end
         end
         if (cs_n) q_bits.delete();
         else if (sck) q_bits.push_back(mosi);
         if (acc) m_busy = BUSY;
         else if (m_busy > 0) m_busy--;
         if (qa.size() > 0) begin
            e_req = 1; e_addr = qa.pop_front(); e_data = qd.pop_front();
         end else e_req = 0;
         m_prev_cs = cs_n;
      end
      #1;
      if (rst_n && !finished) begin
         chk("R2 wel", int'(wel), int'(m_wel));
         chk("R3 session", int'(act), int'(m_act));
         chk("R6 busy", int'(busy), int'(m_busy != 0));
         chk("R8 so_oe", int'(so_oe), int'(m_rb && !cs_n));
         if (so_oe) chk("R8 so level", int'(so), int'(m_busy == 0));
         chk("R4 request", int'(prog_req), int'(e_req));
         if (e_req) begin
            chk("R4 addr", int'(prog_addr), e_addr);
            chk("R1 data", int'(prog_data), e_data);
         end
         if (prog_req) begin
            seen_a.push_back(int'(prog_addr));
            seen_d.push_back(int'(prog_data));
            seen_c.push_back(cyc);
         end
      end
   end

   // watchdog
   always @(posedge clk) begin
      cyc++;
      if (cyc > 200000 && !finished) begin
         finished = 1;
         total++; bad++;
         $display("FAIL watchdog actual=%0d expected=<200000", cyc);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bit(bit b);
      @(negedge clk); mosi = b; sck = 1;
      @(negedge clk); sck = 0;
   endtask

   task automatic send_byte(logic [7:0] v);
      for (int i = 7; i >= 0; i--) send_bit(v[i]);
   endtask

   task automatic sel();
      @(negedge clk); cs_n = 0;
   endtask

   task automatic desel();
      @(negedge clk); cs_n = 1;
      idle(3);
   endtask

   task automatic cmd1(logic [7:0] op);
      sel(); send_byte(op); desel();
   endtask

   task automatic clear_seen();
      seen_a.delete(); seen_d.delete(); seen_c.delete();
   endtask

   initial begin
      idle(3);
      rst_n = 1;
      idle(2);
      // reset state
      chk("R2 reset wel", int'(wel), 0);
      chk("R3 reset session", int'(act), 0);
      chk("R8 reset so_oe", int'(so_oe), 0);
      chk("R4 reset request", int'(prog_req), 0);

      // R3: start without write enable is ignored
      clear_seen();
      sel(); send_byte(8'hAD); send_byte(8'h00); send_byte(8'h01); send_byte(8'h04);
      send_byte(8'h12); send_byte(8'h34); desel();
      chk("R3 no request without wel", seen_a.size(), 0);
      chk("R3 no session without wel", int'(act), 0);

      // R1: strobes while deselected are ignored, then write enable
      send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
      cmd1(8'h06);
      chk("R1 R2 wel set after idle strobes", int'(wel), 1);

      // R7: write-disable cut mid-byte has no effect
      sel(); send_byte(8'h04); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); desel();
      chk("R7 partial frame ignored", int'(wel), 1);

      // R8: enable ready/busy
      cmd1(8'h70);
      sel(); idle(1);
      chk("R8 so_oe when selected", int'(so_oe), 1);
      chk("R8 so ready", int'(so), 1);
      @(negedge clk); cs_n = 1; idle(2);

      // R4: start at odd address, bit 0 ignored
      clear_seen();
      sel(); send_byte(8'hAD); send_byte(8'h00); send_byte(8'h01); send_byte(8'h05);
      send_byte(8'hA5); send_byte(8'h3C); desel();
      chk("R4 two requests", seen_a.size(), 2);
      if (seen_a.size() == 2) begin
         chk("R4 even addr", seen_a[0], 'h104);
         chk("R4 even data", seen_d[0], 'hA5);
         chk("R4 odd addr", seen_a[1], 'h105);
         chk("R4 odd data", seen_d[1], 'h3C);
         chk("R10 consecutive", seen_c[1] - seen_c[0], 1);
      end
      chk("R3 session open", int'(act), 1);

      // R6: follow-on while busy is ignored; R8 so shows busy
      clear_seen();
      sel(); idle(1);
      chk("R8 so busy", int'(so), 0);
      send_byte(8'hAD); send_byte(8'h77); send_byte(8'h88); desel();
      chk("R6 ignored while busy", seen_a.size(), 0);

      // R5: follow-on after busy programs next word
      idle(BUSY + 10);
      clear_seen();
      sel(); idle(1);
      chk("R8 so ready again", int'(so), 1);
      send_byte(8'hAD); send_byte(8'h11); send_byte(8'h22); desel();
      chk("R5 two requests", seen_a.size(), 2);
      if (seen_a.size() == 2) begin
         chk("R5 next even", seen_a[0], 'h106);
         chk("R5 next odd", seen_a[1], 'h107);
         chk("R5 data", seen_d[1], 'h22);
      end

      // R7: six-byte frame inside a session is the wrong length
      idle(BUSY + 10);
      clear_seen();
      sel(); send_byte(8'hAD); send_byte(8'h00); send_byte(8'h02); send_byte(8'h00);
      send_byte(8'h55); send_byte(8'h66); desel();
      chk("R7 wrong length ignored", seen_a.size(), 0);

      // R6: sweep of gaps around the end of busy, model judges each frame
      for (int g = 30; g < 60; g += 3) begin
         idle(g);
         sel(); send_byte(8'hAD); send_byte(8'(g)); send_byte(8'(g + 1)); desel();
      end
      idle(BUSY + 10);

      // R2: write-disable closes the session
      cmd1(8'h04);
      chk("R2 wel cleared", int'(wel), 0);
      chk("R2 session closed", int'(act), 0);

      // R9: top word ends the session, high address bits ignored
      cmd1(8'h06);
      clear_seen();
      sel(); send_byte(8'hAD); send_byte(8'hFF); send_byte(8'hFF); send_byte(8'hFF);
      send_byte(8'h5A); send_byte(8'h69); desel();
      chk("R9 requests", seen_a.size(), 2);
      if (seen_a.size() == 2) begin
         chk("R9 top even", seen_a[0], TOP - 2);
         chk("R9 top odd", seen_a[1], TOP - 1);
      end
      chk("R9 session ended", int'(act), 0);
      chk("R9 wel cleared", int'(wel), 0);

      // R8: disable ready/busy output
      cmd1(8'h80);
      sel(); idle(1);
      chk("R8 so_oe off", int'(so_oe), 0);
      @(negedge clk); cs_n = 1; idle(3);

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule